// File: doc/BRIEF.md
# Serial Port Bit-Clock and Frame-Sync Generator

This block derives the bit clock and the frame-sync signal of an audio serial port from the functional clock it runs on. It is a clock-enable design: the bit clock is a divided level that is sampled and registered by neighbouring logic, and a one-cycle strobe marks the last input cycle of every bit-clock period. The frame logic advances only on that strobe. It either emits a sync pulse at a fixed frame rate or emits one pulse for each transfer request.

A single 30-bit configuration word sets every option, and its field positions are fixed:
- bits [7:0] divide value D
- bits [15:8] sync width W
- bits [27:16] frame period P
- bit 28 sync source (1 periodic, 0 on request)
- bit 29 internal clock select

Two separate enables, one for the divider and one for the frame logic, start these functions, and clearing an enable stops and resets what it controls. Two polarity inputs invert the bit clock and the frame sync at the pins. For symmetric stereo framing with N-bit words, software programs P = 2N-1 and W = N-1. For example, 16-bit words give 31 and 15.

Top module: `sport_rate_gen`

## Requirements
- R1: While the divider runs, `bclk_tick` is high for one input cycle out of every D+1, and the first strobe comes D cycles after the divider starts. With D = 0 the strobe is high on every cycle.
- R2: Counting the cycles of a bit-clock period from 0 (the cycle after a strobe, or the first running cycle), the unpolarised bit clock is high for phases 0 through floor(D/2) and low for the rest of the period.
- R3: With bit 28 set, frame sync is active for W+1 bit clocks out of every P+1. If W is equal to or greater than P, the sync stays active continuously.
- R4: After `fs_en` rises, the frame logic ignores any strobe in that same cycle. The first sync pulse becomes active on the cycle that follows the next strobe. Sync changes occur only on the cycle after a strobe.
- R5: With bit 28 clear, a one-cycle `xfer_req` produces one sync pulse of W+1 bit clocks. The pulse starts at the first strobe in or after the cycle of the request, and it is not repeated.
- R6: While `gen_en` is low, `bclk_tick` stays low and `bclk` stays at its idle level, which equals `clk_pol`. When `gen_en` goes high again, the divider restarts from phase 0.
- R7: While bit 29 is clear, the divider does not run, even with `gen_en` high. No strobe appears and `bclk` stays at its idle level.
- R8: One cycle after `fs_en` is seen low, frame sync is inactive. A transfer request made while `fs_en` is low is discarded and does not produce a pulse once `fs_en` goes high.
- R9: `clk_pol` = 1 inverts `bclk`. `fs_pol` = 1 makes frame sync active-low.
- R10: Directly after the synchronous reset, `bclk_tick` is 0, `bclk` is 0 and `fsync` is 0 when both polarity inputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Functional clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_word | input | 30 | Configuration: D [7:0], W [15:8], P [27:16], sync source [28], internal clock select [29] |
| gen_en | input | 1 | Divider enable; low stops and clears it |
| fs_en | input | 1 | Frame logic enable; low stops and clears it |
| clk_pol | input | 1 | Inverts the bit clock output |
| fs_pol | input | 1 | Makes frame sync active-low |
| xfer_req | input | 1 | Transfer request used when bit 28 is clear |
| bclk | output | 1 | Bit clock level |
| fsync | output | 1 | Frame sync |
| bclk_tick | output | 1 | One-cycle strobe in the last input cycle of each bit-clock period |

## Verification
The bench covers the following corner cases and the fault each one would expose:
- **D = 0.** The strobe and the frame-enable edge fall in the same cycle here. A design that lets that strobe advance the frame would start its first pulse one bit clock early.
- **Width 0 and width equal to the period.** These catch off-by-one faults in the width compare: the design would drop the one-bit pulse entirely, or show a one-bit gap in a sync that should be solid.
- **Request mode, request on a strobe cycle.** This catches a design that latches the request and consumes it one bit clock late.
- **Request mode, fs_en low.** This catches a design that remembers a request made while the frame logic was disabled and emits a stray pulse later.
- **Cleared internal clock select.** This catches a divider that runs regardless of bit 29.

// File: rtl/sport_srg_pkg.sv
package sport_srg_pkg;

    localparam int DIV_W = 8;
    localparam int FSW_W = 8;
    localparam int PER_W = 12;
    localparam int CFG_W = DIV_W + FSW_W + PER_W + 2;

    typedef enum logic {
        FS_ON_REQUEST = 1'b0,
        FS_PERIODIC   = 1'b1
    } fs_src_e;

    // Field order is fixed: a neighbour writes this word as one value.
    typedef struct packed {
        logic               int_clk;
        fs_src_e            fs_src;
        logic [PER_W-1:0]   period;
        logic [FSW_W-1:0]   width;
        logic [DIV_W-1:0]   div;
    } srg_cfg_t;

    function automatic srg_cfg_t decode_cfg(input logic [CFG_W-1:0] w);
        return srg_cfg_t'(w);
    endfunction

    // Last phase of a bit-clock period in which the level is still high.
    function automatic logic [DIV_W-1:0] high_last(input logic [DIV_W-1:0] d);
        return d >> 1;
    endfunction

endpackage

// File: rtl/srg_clk_div.sv
module srg_clk_div
    import sport_srg_pkg::*;
#(
    parameter int W = DIV_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         run,
    input  logic [W-1:0] div,
    output logic         tick,
    output logic         bclk_lvl
);

    logic [W-1:0] phase;
    logic         wrap;

    // >= keeps the counter bounded when the divide value shrinks mid-period
    assign wrap = (phase >= div);

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            phase <= '0;
        end else if (wrap) begin
            phase <= '0;
        end else begin
            phase <= phase + 1'b1;
        end
    end

    assign tick     = run & wrap;
    assign bclk_lvl = run & (phase <= (div >> 1));

endmodule

// File: rtl/srg_frame_gen.sv
module srg_frame_gen
    import sport_srg_pkg::*;
#(
    parameter int PW = PER_W,
    parameter int WW = FSW_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          fs_en,
    input  logic          tick,
    input  fs_src_e       fs_src,
    input  logic          xfer_req,
    input  logic [WW-1:0] width,
    input  logic [PW-1:0] period,
    output logic          fs_act
);

    localparam int PAD = PW - WW;

    logic          fs_en_q;
    logic          start;
    logic          pend;
    logic [PW-1:0] fcnt;
    logic [PW-1:0] fcnt_wrap;
    logic [PW-1:0] width_x;
    logic          req_any;
    logic          in_pulse;

    assign width_x   = {{PAD{1'b0}}, width};
    assign start     = fs_en & ~fs_en_q;
    assign fcnt_wrap = (fcnt >= period) ? '0 : fcnt + 1'b1;
    assign req_any   = pend | xfer_req;
    assign in_pulse  = fs_act & (fcnt != width_x);

    always_ff @(posedge clk) begin
        if (rst) begin
            fs_en_q <= 1'b0;
            fcnt    <= '0;
            fs_act  <= 1'b0;
            pend    <= 1'b0;
        end else begin
            fs_en_q <= fs_en;
            if (!fs_en) begin
                fcnt   <= '0;
                fs_act <= 1'b0;
                pend   <= 1'b0;
            end else if (start) begin
                // next strobe wraps the counter to 0 and opens the first pulse
                fcnt   <= period;
                fs_act <= 1'b0;
                pend   <= 1'b0;
            end else if (fs_src == FS_PERIODIC) begin
                pend <= 1'b0;
                if (tick) begin
                    fcnt   <= fcnt_wrap;
                    fs_act <= (fcnt_wrap <= width_x);
                end
            end else begin
                if (tick) begin
                    if (in_pulse) begin
                        fcnt <= fcnt + 1'b1;
                        pend <= req_any;
                    end else if (req_any) begin
                        fcnt   <= '0;
                        fs_act <= 1'b1;
                        pend   <= 1'b0;
                    end else begin
                        fs_act <= 1'b0;
                    end
                end else begin
                    pend <= req_any;
                end
            end
        end
    end

endmodule

// File: rtl/srg_pin_stage.sv
module srg_pin_stage (
    input  logic bclk_lvl,
    input  logic fs_act,
    input  logic clk_pol,
    input  logic fs_pol,
    output logic bclk,
    output logic fsync
);

    assign bclk  = bclk_lvl ^ clk_pol;
    assign fsync = fs_act ^ fs_pol;

endmodule

// File: rtl/sport_rate_gen.sv
module sport_rate_gen
    import sport_srg_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [CFG_W-1:0] cfg_word,
    input  logic             gen_en,
    input  logic             fs_en,
    input  logic             clk_pol,
    input  logic             fs_pol,
    input  logic             xfer_req,
    output logic             bclk,
    output logic             fsync,
    output logic             bclk_tick
);

    srg_cfg_t cfg;
    logic     run;
    logic     tick;
    logic     bclk_lvl;
    logic     fs_act;

    assign cfg       = decode_cfg(cfg_word);
    assign run       = gen_en & cfg.int_clk;
    assign bclk_tick = tick;

    srg_clk_div #(.W(DIV_W)) u_div (
        .clk      (clk),
        .rst      (rst),
        .run      (run),
        .div      (cfg.div),
        .tick     (tick),
        .bclk_lvl (bclk_lvl)
    );

    srg_frame_gen #(.PW(PER_W), .WW(FSW_W)) u_frame (
        .clk      (clk),
        .rst      (rst),
        .fs_en    (fs_en),
        .tick     (tick),
        .fs_src   (cfg.fs_src),
        .xfer_req (xfer_req),
        .width    (cfg.width),
        .period   (cfg.period),
        .fs_act   (fs_act)
    );

    srg_pin_stage u_pins (
        .bclk_lvl (bclk_lvl),
        .fs_act   (fs_act),
        .clk_pol  (clk_pol),
        .fs_pol   (fs_pol),
        .bclk     (bclk),
        .fsync    (fsync)
    );

endmodule

// File: rtl/sport_rate_gen_chk.sv
module sport_rate_gen_chk
    import sport_srg_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic [CFG_W-1:0] cfg_word,
    input logic             gen_en,
    input logic             fs_en,
    input logic             clk_pol,
    input logic             fs_pol,
    input logic             bclk,
    input logic             fsync,
    input logic             bclk_tick
);

    logic tick_q;

    always_ff @(posedge clk) begin
        if (rst) tick_q <= 1'b0;
        else     tick_q <= bclk_tick;
    end

    // R1
    tick_spacing_chk: assert property (@(posedge clk) disable iff (rst)
        (tick_q && gen_en && $stable(cfg_word) && (cfg_word[7:0] != 8'd0)) |-> !bclk_tick);

    // R6
    gen_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !gen_en |-> (!bclk_tick && (bclk == clk_pol)));

    // R7
    int_clk_chk: assert property (@(posedge clk) disable iff (rst)
        !cfg_word[29] |-> !bclk_tick);

    // R8
    fs_off_chk: assert property (@(posedge clk) disable iff (rst)
        !fs_en |=> (fsync == fs_pol));

    // R4
    fs_on_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(fs_en) && fs_en && $stable(fs_pol) && !tick_q) |-> $stable(fsync));

endmodule

bind sport_rate_gen sport_rate_gen_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .cfg_word  (cfg_word),
    .gen_en    (gen_en),
    .fs_en     (fs_en),
    .clk_pol   (clk_pol),
    .fs_pol    (fs_pol),
    .bclk      (bclk),
    .fsync     (fsync),
    .bclk_tick (bclk_tick)
);

// File: tb/sport_rate_gen_tb.sv
module sport_rate_gen_tb;

    localparam int CLK_PERIOD = 10;

    logic        clk;
    logic        rst;
    logic [29:0] cfg_word;
    logic        gen_en;
    logic        fs_en;
    logic        clk_pol;
    logic        fs_pol;
    logic        xfer_req;
    logic        bclk;
    logic        fsync;
    logic        bclk_tick;

    typedef struct {
        logic  bclk;
        logic  tick;
        logic  fsync;
        bit    fs_care;
        string tag;
    } exp_t;

    exp_t exp_q[$];
    exp_t cur;
    int   checks = 0;
    int   errors = 0;
    bit   done   = 0;

    sport_rate_gen u_dut (
        .clk       (clk),
        .rst       (rst),
        .cfg_word  (cfg_word),
        .gen_en    (gen_en),
        .fs_en     (fs_en),
        .clk_pol   (clk_pol),
        .fs_pol    (fs_pol),
        .xfer_req  (xfer_req),
        .bclk      (bclk),
        .fsync     (fsync),
        .bclk_tick (bclk_tick)
    );

    initial clk = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [29:0] make_cfg(input int d, input int w, input int p,
                                             input bit periodic, input bit intclk);
        logic [7:0]  d8  = d[7:0];
        logic [7:0]  w8  = w[7:0];
        logic [11:0] p12 = p[11:0];
        return {intclk, periodic, p12, w8, d8};
    endfunction

    task automatic push(input logic b, input logic t, input logic f,
                        input bit care, input string tag);
        exp_t e;
        e.bclk = b; e.tick = t; e.fsync = f; e.fs_care = care; e.tag = tag;
        exp_q.push_back(e);
    endtask

    // monitor: compares in the middle of every cycle
    always @(negedge clk) begin
        if (exp_q.size() > 0) begin
            cur = exp_q.pop_front();
            checks++;
            if (bclk !== cur.bclk || bclk_tick !== cur.tick ||
                (cur.fs_care && fsync !== cur.fsync)) begin
                errors++;
                $display("FAIL %s: bclk/tick/fsync = %b/%b/%b expected %b/%b/%b%s",
                         cur.tag, bclk, bclk_tick, fsync, cur.bclk, cur.tick, cur.fsync,
                         cur.fs_care ? "" : " (fsync not checked)");
            end
        end
    end

    // R6 R8: both enables low, outputs settle at idle levels
    task automatic idle_phase(input bit cpol, input bit fpol);
        @(posedge clk); #1;
        gen_en = 0; fs_en = 0; xfer_req = 0; clk_pol = cpol; fs_pol = fpol;
        push(cpol, 1'b0, fpol, 0, "R6");
        @(posedge clk); #1;
        push(cpol, 1'b0, fpol, 1, "R6 R8");
    endtask

    // R1 R2 R3 R4 R9: periodic frames
    task automatic run_periodic(input int d, input int w, input int p,
                                input bit cpol, input bit fpol, input int n);
        int k = 0;
        idle_phase(cpol, fpol);
        @(posedge clk); #1;
        cfg_word = make_cfg(d, w, p, 1'b1, 1'b1);
        gen_en = 1; fs_en = 1;
        for (int j = 0; j < n; j++) begin
            bit tk, bh, fs;
            if (j > 0) begin @(posedge clk); #1; end
            tk = ((j % (d + 1)) == d);
            bh = ((j % (d + 1)) <= (d / 2));
            fs = (k > 0) && (((k - 1) % (p + 1)) <= w);
            push(bh ^ cpol, tk, fs ^ fpol, 1, "R1 R2 R3 R4 R9");
            if (tk && j >= 1) k++;
        end
    endtask

    // R5: one pulse per request
    task automatic run_request(input int d, input int w, input int r, input int n);
        int  c = 0;
        bit  armed = 0;
        idle_phase(1'b0, 1'b0);
        @(posedge clk); #1;
        cfg_word = make_cfg(d, w, 40, 1'b0, 1'b1);
        gen_en = 1; fs_en = 1;
        for (int j = 0; j < n; j++) begin
            bit tk, bh, fs;
            if (j > 0) begin @(posedge clk); #1; end
            xfer_req = (j == r);
            tk = ((j % (d + 1)) == d);
            bh = ((j % (d + 1)) <= (d / 2));
            fs = (c >= 1) && (c <= w + 1);
            push(bh, tk, fs, 1, "R5");
            if (tk && j >= 1) begin
                if (armed) c++;
                else if (j >= r) begin armed = 1; c = 1; end
            end
        end
        xfer_req = 0;
    endtask

    // R7: internal clock select cleared
    task automatic run_no_intclk(input int n);
        idle_phase(1'b0, 1'b0);
        @(posedge clk); #1;
        cfg_word = make_cfg(0, 1, 7, 1'b1, 1'b0);
        gen_en = 1; fs_en = 1;
        for (int j = 0; j < n; j++) begin
            if (j > 0) begin @(posedge clk); #1; end
            push(1'b0, 1'b0, 1'b0, 1, "R7");
        end
    endtask

    // R8: request while frame logic is off is dropped
    task automatic run_req_while_off(input int d, input int n);
        idle_phase(1'b0, 1'b0);
        @(posedge clk); #1;
        cfg_word = make_cfg(d, 2, 40, 1'b0, 1'b1);
        gen_en = 1; fs_en = 0;
        for (int j = 0; j < n; j++) begin
            if (j > 0) begin @(posedge clk); #1; end
            xfer_req = (j == 1);
            if (j == 4) fs_en = 1;
            push(((j % (d + 1)) <= (d / 2)), ((j % (d + 1)) == d), 1'b0, 1, "R8");
        end
        xfer_req = 0;
    endtask

    // R6: divider stopped mid-run
    task automatic run_gen_off(input bit cpol, input int n);
        @(posedge clk); #1;
        gen_en = 0;
        for (int j = 0; j < n; j++) begin
            if (j > 0) begin @(posedge clk); #1; end
            push(cpol, 1'b0, 1'b0, 0, "R6");
        end
    endtask

    initial begin
        rst = 1; cfg_word = '0; gen_en = 0; fs_en = 0;
        clk_pol = 0; fs_pol = 0; xfer_req = 0;
        repeat (3) @(posedge clk);
        #1;
        rst = 0;
        push(1'b0, 1'b0, 1'b0, 1, "R10");

        run_periodic(3, 15, 31, 1'b0, 1'b0, 300);
        run_gen_off(1'b0, 5);
        run_periodic(0, 2, 7, 1'b1, 1'b1, 40);
        run_periodic(2, 0, 4, 1'b0, 1'b0, 60);
        run_periodic(1, 5, 5, 1'b0, 1'b1, 30);
        run_gen_off(1'b0, 4);
        run_request(2, 3, 7, 40);
        run_request(0, 0, 3, 15);
        run_request(3, 1, 3, 40);
        run_no_intclk(10);
        run_req_while_off(1, 30);

        while (exp_q.size() > 0) @(negedge clk);
        @(negedge clk);
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: run did not complete, actual hung expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule